// File: doc/BRIEF.md
# Transfer Channel Configuration Registers

This block is the configuration side of one transfer channel in a small DMA controller. It listens as a bus slave on an 8-bit data, 16-bit address processor bus. When the processor writes inside the block's own address window, the written byte lands in one of four byte-wide registers. Those registers form a transfer pointer and an enable bit, and both go straight to the DMA engine.

The pointer advances on its own. Each time the engine signals with a one-cycle acknowledge pulse that a transfer has completed, the pointer moves up by one. Software therefore writes the start address once for each block transfer and does not reload it byte by byte.

The window tag and the channel slot are parameters, so several copies of the block can sit side by side at different channel offsets inside the same window. The pointer width is also a parameter, from 2 to 16 bits. All state changes on the rising clock edge, and the outputs come straight from registers.

Top module: `xfer_chan_cfg`

## Requirements
- R1: A synchronous active-high reset clears the pointer to zero and the enable bit to 0. Both outputs read those values after the first rising edge at which reset is sampled high.
- R2: A selected write with index 0 (address bits 1:0 = 00) loads the data byte into pointer bits 7:0. The other pointer bits are left unchanged.
- R3: A selected write with index 1 (address bits 1:0 = 01) loads the data byte into pointer bits PTR_W-1:8. The low byte is left unchanged.
- R4: A selected write with index 2 (address bits 1:0 = 10) loads data bit 0 into the enable bit. Data bits 7:1 have no effect.
- R5: A selected write with index 3 (address bits 1:0 = 11) changes neither the pointer nor the enable bit.
- R6: A write counts as selected only when all three conditions hold: address bits 14:8 equal WIN_TAG (default 7Fh), the slot select input is low, and address bits 3:2 equal CHAN_SLOT (default 0). Address bit 15 and bits 7:4 do not take part in the decode. A write that fails any condition changes nothing.
- R7: An acknowledge pulse in a cycle with no pointer-byte write adds one to the pointer.
- R8: When the pointer is all ones, an acknowledge wraps it to zero.
- R9: When a pointer-byte write and an acknowledge fall in the same cycle, the written byte is taken, the other byte keeps its value, and no increment happens.
- R10: When the write strobe is low, no register changes, even if the address and slot select match.
- R11: An enable write and an acknowledge in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address bus |
| bus_wdata | input | 8 | Processor write data |
| slot_sel_n | input | 1 | Slot select, active low |
| bus_wr | input | 1 | Write strobe, active high |
| xfer_ack | input | 1 | One-cycle pulse from the engine when a transfer completes |
| xfer_ptr | output | PTR_W | Transfer address pointer |
| xfer_en | output | 1 | Channel enable |

## Verification
Every register write and every acknowledge has its effect on the first rising edge after the inputs are presented. The new pointer or enable value is therefore due exactly one edge after the stimulus, with no further latency. The driver applies each stimulus on a falling edge and pushes the expected pointer and enable into the queue just after the following rising edge. The monitor pops and compares on the next falling edge, so every comparison falls on the single cycle in which that result is due and never straddles a clock edge.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SEL_PTR_LO = 2'd0,
      SEL_PTR_HI = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_SPARE  = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic              hit;
      cfg_sel_e          sel;
      logic [BYTE_W-1:0] data;
   } cfg_wr_t;

   function automatic int bytes_for(input int w);
      return (w + BYTE_W - 1) / BYTE_W;
   endfunction

endpackage

// File: rtl/cfg_window_dec.sv
module cfg_window_dec
   import xcc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_HI    = 14,
   parameter int WIN_LO    = 8,
   parameter int WIN_TAG   = 'h7F,
   parameter int CH_HI     = 3,
   parameter int CH_LO     = 2,
   parameter int CHAN_SLOT = 0,
   parameter int IDX_LO    = 0
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              slot_n_i,
   input  logic              wr_i,
   output cfg_wr_t           wr_o
);

   localparam int WIN_W = WIN_HI - WIN_LO + 1;
   localparam int CH_W  = CH_HI - CH_LO + 1;

   logic win_match;
   logic chan_match;
   logic unused_addr_bits;

   assign win_match  = (addr_i[WIN_HI:WIN_LO] == WIN_W'(WIN_TAG));
   assign chan_match = (addr_i[CH_HI:CH_LO] == CH_W'(CHAN_SLOT));

   assign wr_o.hit  = win_match & chan_match & ~slot_n_i & wr_i;
   assign wr_o.sel  = cfg_sel_e'(addr_i[IDX_LO+1:IDX_LO]);
   assign wr_o.data = data_i;

   // bits outside the three decoded fields are deliberately ignored
   assign unused_addr_bits = ^addr_i;

endmodule

// File: rtl/cfg_reg_lanes.sv
module cfg_reg_lanes
   import xcc_pkg::*;
#(
   parameter  int PTR_W = 16,
   localparam int NB    = bytes_for(PTR_W)
) (
   input  cfg_wr_t           wr_i,
   output logic [NB-1:0]     byte_ld_o,
   output logic              ctrl_ld_o,
   output logic [BYTE_W-1:0] data_o
);

   // one load strobe per pointer byte; index b addresses byte b
   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign byte_ld_o[b] = wr_i.hit && (wr_i.sel == cfg_sel_e'(2'(b)));
   end

   assign ctrl_ld_o = wr_i.hit && (wr_i.sel == SEL_CTRL);
   assign data_o    = wr_i.data;

endmodule

// File: rtl/cfg_ptr_counter.sv
module cfg_ptr_counter
   import xcc_pkg::*;
#(
   parameter  int PTR_W = 16,
   localparam int NB    = bytes_for(PTR_W),
   localparam int PAD_W = NB * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NB-1:0]     byte_ld_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              adv_i,
   output logic [PTR_W-1:0]  ptr_o
);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_d;
   logic [PAD_W-1:0] merged;

   always_comb begin
      merged = PAD_W'(ptr_q);
      for (int b = 0; b < NB; b++) begin
         if (byte_ld_i[b]) merged[b*BYTE_W +: BYTE_W] = data_i;
      end
   end

   // processor load has priority over the engine advance
   always_comb begin
      if (|byte_ld_i)  ptr_d = merged[PTR_W-1:0];
      else if (adv_i)  ptr_d = ptr_q + PTR_W'(1);
      else             ptr_d = ptr_q;
   end

   if (PAD_W > PTR_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^merged[PAD_W-1:PTR_W];
   end

   always_ff @(posedge clk) begin
      if (rst) ptr_q <= '0;
      else     ptr_q <= ptr_d;
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/xfer_chan_cfg.sv
module xfer_chan_cfg
   import xcc_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int WIN_TAG   = 'h7F,
   parameter int CHAN_SLOT = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [15:0]      bus_addr,
   input  logic [7:0]       bus_wdata,
   input  logic             slot_sel_n,
   input  logic             bus_wr,
   input  logic             xfer_ack,
   output logic [PTR_W-1:0] xfer_ptr,
   output logic             xfer_en
);

   localparam int ADDR_W = 16;
   localparam int NB     = bytes_for(PTR_W);

   if (PTR_W < 2 || PTR_W > 2 * BYTE_W) begin : g_bad_width
      $error("xfer_chan_cfg: PTR_W must lie in 2..16");
   end
   if (WIN_TAG < 0 || WIN_TAG > 127) begin : g_bad_tag
      $error("xfer_chan_cfg: WIN_TAG must fit in 7 bits");
   end
   if (CHAN_SLOT < 0 || CHAN_SLOT > 3) begin : g_bad_slot
      $error("xfer_chan_cfg: CHAN_SLOT must lie in 0..3");
   end

   cfg_wr_t           wr_req;
   logic [NB-1:0]     byte_ld;
   logic              ctrl_ld;
   logic [BYTE_W-1:0] ld_data;
   logic              en_q;

   cfg_window_dec #(
      .ADDR_W(ADDR_W), .WIN_HI(14), .WIN_LO(8), .WIN_TAG(WIN_TAG),
      .CH_HI(3), .CH_LO(2), .CHAN_SLOT(CHAN_SLOT), .IDX_LO(0)
   ) u_dec (
      .addr_i  (bus_addr),
      .data_i  (bus_wdata),
      .slot_n_i(slot_sel_n),
      .wr_i    (bus_wr),
      .wr_o    (wr_req)
   );

   cfg_reg_lanes #(.PTR_W(PTR_W)) u_lanes (
      .wr_i     (wr_req),
      .byte_ld_o(byte_ld),
      .ctrl_ld_o(ctrl_ld),
      .data_o   (ld_data)
   );

   cfg_ptr_counter #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .byte_ld_i(byte_ld),
      .data_i   (ld_data),
      .adv_i    (xfer_ack),
      .ptr_o    (xfer_ptr)
   );

   always_ff @(posedge clk) begin
      if (rst)          en_q <= 1'b0;
      else if (ctrl_ld) en_q <= ld_data[0];
   end

   assign xfer_en = en_q;

endmodule

// File: rtl/xfer_chan_cfg_chk.sv
module xfer_chan_cfg_chk #(
   parameter int PTR_W     = 16,
   parameter int WIN_TAG   = 'h7F,
   parameter int CHAN_SLOT = 0
) (
   input logic             clk,
   input logic             rst,
   input logic [15:0]      bus_addr,
   input logic [7:0]       bus_wdata,
   input logic             slot_sel_n,
   input logic             bus_wr,
   input logic             xfer_ack,
   input logic [PTR_W-1:0] xfer_ptr,
   input logic             xfer_en
);

   logic hit;
   logic ptr_hit;

   assign hit = (bus_addr[14:8] == 7'(WIN_TAG)) && !slot_sel_n &&
                (bus_addr[3:2] == 2'(CHAN_SLOT)) && bus_wr;
   assign ptr_hit = hit && ((bus_addr[1:0] == 2'd0) ||
                            ((bus_addr[1:0] == 2'd1) && (PTR_W > 8)));

   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (xfer_ptr == '0 && !xfer_en));

   assert_low_byte_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit && bus_addr[1:0] == 2'd0))
      |-> (xfer_ptr[7:0] == $past(bus_wdata)));

   assert_enable_load_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit && bus_addr[1:0] == 2'd2))
      |-> (xfer_en == $past(bus_wdata[0])));

   assert_spare_ignored_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hit && bus_addr[1:0] == 2'd3) && !$past(xfer_ack))
      |-> ($stable(xfer_ptr) && $stable(xfer_en)));

   assert_unselected_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(hit) && !$past(xfer_ack))
      |-> ($stable(xfer_ptr) && $stable(xfer_en)));

   assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(xfer_ack) && !$past(ptr_hit))
      |-> (xfer_ptr == $past(xfer_ptr) + PTR_W'(1)));

   assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(xfer_ack) && !$past(ptr_hit) && ($past(xfer_ptr) == '1))
      |-> (xfer_ptr == '0));

   if (PTR_W > 8) begin : g_hi
      assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(hit && bus_addr[1:0] == 2'd0 && xfer_ack))
         |-> (xfer_ptr[PTR_W-1:8] == $past(xfer_ptr[PTR_W-1:8])));
   end

endmodule

bind xfer_chan_cfg xfer_chan_cfg_chk #(
   .PTR_W(PTR_W), .WIN_TAG(WIN_TAG), .CHAN_SLOT(CHAN_SLOT)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .slot_sel_n(slot_sel_n), .bus_wr(bus_wr), .xfer_ack(xfer_ack),
   .xfer_ptr(xfer_ptr), .xfer_en(xfer_en)
);

// File: tb/sim_xfer_chan_cfg.sv
`timescale 1ns/1ps
module sim_xfer_chan_cfg;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        slot_sel_n = 1'b1;
   logic        bus_wr = 1'b0;
   logic        xfer_ack = 1'b0;
   logic [15:0] xfer_ptr;
   logic        xfer_en;

   always #2.5 clk = ~clk;

   xfer_chan_cfg u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .slot_sel_n(slot_sel_n), .bus_wr(bus_wr), .xfer_ack(xfer_ack),
      .xfer_ptr(xfer_ptr), .xfer_en(xfer_en)
   );

   typedef struct {
      logic [15:0] p;
      logic        e;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          fails = 0;
   logic [15:0] m_ptr = '0;
   logic        m_en = 1'b0;
   bit          done = 1'b0;

   task automatic step(input logic r, input logic [15:0] a, input logic [7:0] d,
                       input logic sn, input logic w, input logic k, input string tag);
      logic sel;
      logic pw;
      exp_t item;
      @(negedge clk);
      rst = r; bus_addr = a; bus_wdata = d; slot_sel_n = sn; bus_wr = w; xfer_ack = k;
      @(posedge clk);
      #1;
      sel = (a[14:8] == 7'h7F) && !sn && (a[3:2] == 2'd0) && w;
      pw  = sel && (a[1:0] == 2'd0 || a[1:0] == 2'd1);
      if (r) begin
         m_ptr = '0; m_en = 1'b0;
      end else begin
         if (sel && a[1:0] == 2'd0) m_ptr[7:0]  = d;
         if (sel && a[1:0] == 2'd1) m_ptr[15:8] = d;
         if (sel && a[1:0] == 2'd2) m_en = d[0];
         if (k && !pw) m_ptr = m_ptr + 16'd1;
      end
      item.p = m_ptr; item.e = m_en; item.tag = tag;
      q.push_back(item);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (xfer_ptr !== e.p || xfer_en !== e.e) begin
               fails++;
               $display("FAIL %s: ptr=%h en=%b expected ptr=%h en=%b",
                        e.tag, xfer_ptr, xfer_en, e.p, e.e);
            end
         end
      end
   end

   initial begin
      step(1, 16'h0000, 8'h00, 1, 0, 0, "R1 reset");
      step(1, 16'h0000, 8'h00, 1, 0, 0, "R1 reset held");
      step(0, 16'h7F00, 8'h34, 0, 1, 0, "R2 low byte");
      step(0, 16'h7F01, 8'h12, 0, 1, 0, "R3 high byte");
      step(0, 16'h7F02, 8'hFE, 0, 1, 0, "R4 bit0 only");
      step(0, 16'h7F02, 8'h01, 0, 1, 0, "R4 enable set");
      step(0, 16'h7F03, 8'hFF, 0, 1, 0, "R5 spare index");
      step(0, 16'h7F00, 8'h99, 1, 1, 0, "R6 slot high");
      step(0, 16'h7E00, 8'h99, 0, 1, 0, "R6 window miss");
      step(0, 16'h7F04, 8'h99, 0, 1, 0, "R6 channel miss");
      step(0, 16'h7FF0, 8'h56, 0, 1, 0, "R6 bits 7:4 ignored");
      step(0, 16'hFF01, 8'h78, 0, 1, 0, "R6 bit15 ignored");
      step(0, 16'h7F00, 8'hAA, 0, 0, 0, "R10 strobe low");
      step(0, 16'h0000, 8'h00, 1, 0, 1, "R7 advance");
      step(0, 16'h0000, 8'h00, 1, 0, 1, "R7 advance");
      step(0, 16'h0000, 8'h00, 1, 0, 0, "R7 idle hold");
      step(0, 16'h7F00, 8'hFF, 0, 1, 1, "R9 low write wins");
      step(0, 16'h0000, 8'h00, 1, 0, 1, "R7 byte carry");
      step(0, 16'h7F01, 8'h20, 0, 1, 1, "R9 high write wins");
      step(0, 16'h7F02, 8'h00, 0, 1, 1, "R11 enable and ack");
      step(0, 16'h7F03, 8'h00, 0, 1, 1, "R5 spare with ack");
      step(0, 16'h7F00, 8'hFF, 0, 1, 0, "R2 load ff");
      step(0, 16'h7F01, 8'hFF, 0, 1, 0, "R3 load ff");
      step(0, 16'h0000, 8'h00, 1, 0, 1, "R8 wrap");
      step(0, 16'h0000, 8'h00, 1, 0, 1, "R8 after wrap");
      step(0, 16'h7F02, 8'h03, 0, 1, 0, "R4 enable again");
      step(1, 16'h7F00, 8'h55, 0, 1, 1, "R1 reset over write");
      step(0, 16'h0000, 8'h00, 1, 0, 0, "R1 after reset");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule